// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the condition and control flags of a small 16-bit processor. Each cycle it can take the flag candidates that the ALU produces for the current result, explicit single-bit writes from software, a whole-byte restore of the visible flags (for example when the flags come back off the stack), and a strobe raised when the core starts to service an interrupt or exception. Beside the eight visible flags it keeps a hidden byte of scratch state. Multi-cycle operations such as multiply use that byte, and it is wiped at the end of every instruction.

The visible byte has a fixed layout that the rest of the core decodes: bit 0 interrupt enable, bit 1 negative, bit 2 zero, bit 3 overflow, bit 4 extended carry, bit 5 carry, bit 6 division mode, bit 7 user flag. The operation class tells the register which flags a result may touch. Arithmetic updates negative, zero, overflow, carry and extended carry. Logical operations update negative and zero, clear overflow, and keep both carries, so a multi-word arithmetic chain survives them. Interrupt enable, division mode and the user flag never follow a result. The branch unit reads the user flag through two ready-made condition outputs.

Top module: `status_flags`

## Requirements
- R1: After reset the visible byte and the scratch byte are all zero, so the user-clear condition is 1 and the user-set condition is 0.
- R2: With opClass = 2'b01 (arithmetic), bit 1 (negative) takes result bit 15, bit 2 (zero) is set exactly when all 16 result bits are zero, bit 3 (overflow) takes ovIn, and both bit 5 (carry) and bit 4 (extended carry) take carryIn.
- R3: With opClass = 2'b10 (logical), bits 1 and 2 update as in R2, bit 3 is cleared, and bits 4 and 5 keep their values.
- R4: With opClass = 2'b00 or 2'b11, result, carryIn and ovIn have no effect on any flag.
- R5: Bit 0 (interrupt enable), bit 6 (division mode) and bit 7 (user flag) never change because of a result under any opClass. They change only through a bit write, a byte load or, for bit 0, interrupt entry.
- R6: When bitWe is high, the visible bit selected by bitSel (0..7, same layout) takes bitVal on the next edge. This write wins over a result update of that same bit.
- R7: When byteLoad is high, the whole visible byte takes byteIn on the next edge. This overrides result updates and bit writes in the same cycle.
- R8: When intEntry is high, bit 0 is 0 after the next edge, whatever bit write or byte load happens in the same cycle. The other bits follow their normal rules.
- R9: uSet equals bit 7 of the visible byte and uClr equals its inverse, with no extra cycle of delay.
- R10: scratchWe loads scratchIn into the hidden byte. instrEnd clears it and wins over scratchWe in the same cycle. No flag activity changes the hidden byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opClass | input | 2 | Result class: 01 arithmetic, 10 logical, 00/11 none |
| result | input | 16 | ALU result for flag evaluation |
| carryIn | input | 1 | ALU carry candidate |
| ovIn | input | 1 | ALU overflow candidate |
| bitWe | input | 1 | Explicit single-bit write strobe |
| bitSel | input | 3 | Visible bit position to write |
| bitVal | input | 1 | Value for the explicit bit write |
| byteLoad | input | 1 | Whole visible byte load strobe |
| byteIn | input | 8 | Visible byte value to load |
| intEntry | input | 1 | Interrupt/exception service strobe |
| scratchWe | input | 1 | Hidden byte write strobe |
| scratchIn | input | 8 | Hidden byte value |
| instrEnd | input | 1 | End of instruction, clears hidden byte |
| flags | output | 8 | Visible flag byte |
| scratch | output | 8 | Hidden scratch byte |
| uSet | output | 1 | Condition: user flag set |
| uClr | output | 1 | Condition: user flag clear |

## Verification
The assertions assume that every strobe is a clean synchronous level that is sampled only at the rising edge, and that bitSel is meaningful only while bitWe is high. They place no restriction on combining strobes, because the priority order among result update, bit write, byte load and interrupt entry is itself part of the checked behaviour. The stimulus changes inputs 2 ns after each rising edge. It deliberately overlaps byte loads, bit writes, interrupt entry and result updates in one cycle so that every priority rule is exercised.

// File: rtl/status_flags_pkg.sv
package status_flags_pkg;
  localparam int FLAG_W = 8;
  localparam int SCR_W  = 8;

  // Visible bit positions (decoded by branch and stack logic)
  localparam int B_I = 0;
  localparam int B_N = 1;
  localparam int B_Z = 2;
  localparam int B_V = 3;
  localparam int B_X = 4;
  localparam int B_C = 5;
  localparam int B_D = 6;
  localparam int B_U = 7;

  localparam logic [1:0] OP_NONE  = 2'b00;
  localparam logic [1:0] OP_ARITH = 2'b01;
  localparam logic [1:0] OP_LOGIC = 2'b10;

  typedef struct packed {
    logic              updNZ;
    logic              updVC;
    logic              updX;
    logic              clrV;
    logic [FLAG_W-1:0] bitMask;
    logic              bitVal;
    logic              loadByte;
    logic              clrI;
    logic              scrWe;
    logic              scrClr;
  } sfStrobe_t;
endpackage

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import status_flags_pkg::*;
#(
  parameter int SEL_W = $clog2(FLAG_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opClass,
  input  logic             bitWe,
  input  logic [SEL_W-1:0] bitSel,
  input  logic             bitVal,
  input  logic             byteLoad,
  input  logic             intEntry,
  input  logic             scratchWe,
  input  logic             instrEnd,
  output sfStrobe_t        str
);
  logic isArith;
  logic isLogic;
  logic [FLAG_W-1:0] selMask;

  assign isArith = (opClass == OP_ARITH);
  assign isLogic = (opClass == OP_LOGIC);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_sel
    assign selMask[i] = bitWe && (bitSel == SEL_W'(i));
  end

  always_comb begin
    str          = '0;
    str.updNZ    = isArith || isLogic;
    str.updVC    = isArith;
    str.updX     = isArith;
    str.clrV     = isLogic;
    str.bitMask  = selMask;
    str.bitVal   = bitVal;
    str.loadByte = byteLoad;
    str.clrI     = intEntry;
    str.scrWe    = scratchWe;
    str.scrClr   = instrEnd;
  end

  // R6: at most one visible bit addressed per cycle
  a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(str.bitMask));
  // R4: no-op class requests no result update
  a_r4_none_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (opClass == OP_NONE) |-> !(str.updNZ || str.updVC || str.updX || str.clrV));
endmodule

// File: rtl/sf_datapath.sv
module sf_datapath
  import status_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfStrobe_t         str,
  input  logic [DATA_W-1:0] result,
  input  logic              carryIn,
  input  logic              ovIn,
  input  logic [FLAG_W-1:0] byteIn,
  input  logic [SCR_W-1:0]  scratchIn,
  output logic [FLAG_W-1:0] flags,
  output logic [SCR_W-1:0]  scratch
);
  localparam int MSB = DATA_W - 1;

  logic [FLAG_W-1:0] flagsNxt;
  logic [SCR_W-1:0]  scratchNxt;

  always_comb begin
    flagsNxt = flags;
    if (str.updNZ) begin
      flagsNxt[B_N] = result[MSB];
      flagsNxt[B_Z] = ~|result;
    end
    if (str.updVC) begin
      flagsNxt[B_V] = ovIn;
      flagsNxt[B_C] = carryIn;
    end
    if (str.clrV) flagsNxt[B_V] = 1'b0;
    if (str.updX) flagsNxt[B_X] = carryIn;
    for (int i = 0; i < FLAG_W; i++) begin
      if (str.bitMask[i]) flagsNxt[i] = str.bitVal;
    end
    if (str.loadByte) flagsNxt = byteIn;
    if (str.clrI) flagsNxt[B_I] = 1'b0;
  end

  always_comb begin
    scratchNxt = scratch;
    if (str.scrClr)     scratchNxt = '0;
    else if (str.scrWe) scratchNxt = scratchIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      scratch <= '0;
    end else begin
      flags   <= flagsNxt;
      scratch <= scratchNxt;
    end
  end

  // R8: interrupt entry always leaves interrupt enable cleared
  a_r8_int_clears: assert property (@(posedge clk) disable iff (!rstN)
    str.clrI |=> !flags[B_I]);
  // R7: byte load replaces the visible byte
  a_r7_load: assert property (@(posedge clk) disable iff (!rstN)
    (str.loadByte && !str.clrI) |=> (flags == $past(byteIn)));
  // R5: user flag moves only on explicit write
  a_r5_u_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!str.loadByte && !str.bitMask[B_U]) |=> $stable(flags[B_U]));
  // R5: division mode moves only on explicit write
  a_r5_d_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!str.loadByte && !str.bitMask[B_D]) |=> $stable(flags[B_D]));
  // R3: extended carry untouched outside arithmetic
  a_r3_x_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!str.updX && !str.loadByte && !str.bitMask[B_X]) |=> $stable(flags[B_X]));
  // R2: zero flag follows the result
  a_r2_zero: assert property (@(posedge clk) disable iff (!rstN)
    (str.updNZ && !str.loadByte && !str.bitMask[B_Z])
      |=> (flags[B_Z] == ($past(result) == '0)));
  // R10: end of instruction wipes the hidden byte
  a_r10_scr_clr: assert property (@(posedge clk) disable iff (!rstN)
    str.scrClr |=> (scratch == '0));
endmodule

// File: rtl/status_flags.sv
module status_flags
  import status_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opClass,
  input  logic [DATA_W-1:0] result,
  input  logic              carryIn,
  input  logic              ovIn,
  input  logic              bitWe,
  input  logic [2:0]        bitSel,
  input  logic              bitVal,
  input  logic              byteLoad,
  input  logic [7:0]        byteIn,
  input  logic              intEntry,
  input  logic              scratchWe,
  input  logic [7:0]        scratchIn,
  input  logic              instrEnd,
  output logic [7:0]        flags,
  output logic [7:0]        scratch,
  output logic              uSet,
  output logic              uClr
);
  sfStrobe_t str;

  sf_ctrl #(.SEL_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .opClass(opClass), .bitWe(bitWe),
    .bitSel(bitSel), .bitVal(bitVal), .byteLoad(byteLoad),
    .intEntry(intEntry), .scratchWe(scratchWe), .instrEnd(instrEnd),
    .str(str)
  );

  sf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .result(result),
    .carryIn(carryIn), .ovIn(ovIn), .byteIn(byteIn),
    .scratchIn(scratchIn), .flags(flags), .scratch(scratch)
  );

  assign uSet = flags[B_U];
  assign uClr = ~flags[B_U];

  // R9: condition outputs are complementary
  a_r9_cond_pair: assert property (@(posedge clk) disable iff (!rstN)
    uSet != uClr);
endmodule

// File: tb/status_flags_tb.sv
module status_flags_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [1:0]  opClass = 0;
  logic [15:0] result = 0;
  logic        carryIn = 0, ovIn = 0, bitWe = 0, bitVal = 0;
  logic [2:0]  bitSel = 0;
  logic        byteLoad = 0, intEntry = 0, scratchWe = 0, instrEnd = 0;
  logic [7:0]  byteIn = 0, scratchIn = 0;
  logic [7:0]  flags, scratch;
  logic        uSet, uClr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mFlags = 0;
  logic [7:0] mScr   = 0;

  always #10 clk = ~clk;

  status_flags u_dut (
    .clk(clk), .rstN(rstN), .opClass(opClass), .result(result),
    .carryIn(carryIn), .ovIn(ovIn), .bitWe(bitWe), .bitSel(bitSel),
    .bitVal(bitVal), .byteLoad(byteLoad), .byteIn(byteIn),
    .intEntry(intEntry), .scratchWe(scratchWe), .scratchIn(scratchIn),
    .instrEnd(instrEnd), .flags(flags), .scratch(scratch),
    .uSet(uSet), .uClr(uClr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Reference built from the requirements, applied to the inputs held now
  task automatic model();
    logic [7:0] f;
    f = mFlags;
    if (opClass == 2'b01) begin
      f[1] = result[15]; f[2] = (result == 0);
      f[3] = ovIn; f[5] = carryIn; f[4] = carryIn;
    end else if (opClass == 2'b10) begin
      f[1] = result[15]; f[2] = (result == 0); f[3] = 1'b0;
    end
    if (bitWe) f[bitSel] = bitVal;
    if (byteLoad) f = byteIn;
    if (intEntry) f[0] = 1'b0;
    mFlags = f;
    if (instrEnd) mScr = 0;
    else if (scratchWe) mScr = scratchIn;
  endtask

  task automatic idle();
    opClass = 0; result = 0; carryIn = 0; ovIn = 0; bitWe = 0; bitSel = 0;
    bitVal = 0; byteLoad = 0; byteIn = 0; intEntry = 0;
    scratchWe = 0; scratchIn = 0; instrEnd = 0;
  endtask

  task automatic step(input string req);
    model();
    @(posedge clk); #2;
    idle();
    chk(req, flags, mFlags);
    chk({req, " scratch"}, scratch, mScr);
    chk({req, " uSet"}, {7'd0, uSet}, {7'd0, mFlags[7]});
    chk({req, " uClr"}, {7'd0, uClr}, {7'd0, ~mFlags[7]});
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 8'h00);
    chk("R1 scratch", scratch, 8'h00);
    chk("R1 uClr", {7'd0, uClr}, 8'h01);
  endtask

  task automatic t_arith();
    opClass = 2'b01; result = 16'h8000; carryIn = 1; ovIn = 1; step("R2 neg carry ovf");
    chk("R2 literal", flags, 8'h3A);
    opClass = 2'b01; result = 16'h0000; step("R2 zero");
    chk("R2 literal zero", flags, 8'h04);
    opClass = 2'b01; result = 16'h0001; carryIn = 1; ovIn = 1; step("R2 pos");
  endtask

  task automatic t_logic();
    opClass = 2'b10; result = 16'h0000; step("R3 logic zero");
    chk("R3 literal", flags, 8'h34);
    opClass = 2'b10; result = 16'hFFFF; step("R3 logic neg");
    chk("R3 literal neg", flags, 8'h32);
  endtask

  task automatic t_none();
    opClass = 2'b00; result = 16'h0000; carryIn = 0; ovIn = 1; step("R4 class 00");
    opClass = 2'b11; result = 16'h0000; carryIn = 0; ovIn = 1; step("R4 class 11");
    chk("R4 literal", flags, 8'h32);
  endtask

  task automatic t_bits();
    bitWe = 1; bitSel = 7; bitVal = 1; step("R6 set U");
    bitWe = 1; bitSel = 6; bitVal = 1; step("R6 set D");
    bitWe = 1; bitSel = 0; bitVal = 1; step("R6 set I");
    opClass = 2'b01; result = 16'h0000; carryIn = 0; ovIn = 0; step("R5 arith keeps I D U");
    chk("R5 literal", flags, 8'hC5);
    opClass = 2'b10; result = 16'hFFFF; step("R5 logic keeps I D U");
    opClass = 2'b01; result = 16'h8000; bitWe = 1; bitSel = 1; bitVal = 0; step("R6 bit beats result");
    chk("R6 literal", flags[1] ? 8'h01 : 8'h00, 8'h00);
    bitWe = 1; bitSel = 7; bitVal = 0; step("R9 clear U");
  endtask

  task automatic t_load();
    byteLoad = 1; byteIn = 8'hA5; opClass = 2'b01; result = 16'h8000; carryIn = 1;
    bitWe = 1; bitSel = 2; bitVal = 0; step("R7 load overrides");
    chk("R7 literal", flags, 8'hA5);
  endtask

  task automatic t_int();
    intEntry = 1; step("R8 clear I");
    chk("R8 literal", flags, 8'hA4);
    bitWe = 1; bitSel = 0; bitVal = 1; intEntry = 1; step("R8 beats bit write");
    byteLoad = 1; byteIn = 8'hFF; intEntry = 1; step("R8 beats byte load");
    chk("R8 literal load", flags, 8'hFE);
  endtask

  task automatic t_scratch();
    scratchWe = 1; scratchIn = 8'h5A; step("R10 write");
    opClass = 2'b01; result = 16'h1234; byteLoad = 1; byteIn = 8'h00; step("R10 flags leave scratch");
    chk("R10 literal", scratch, 8'h5A);
    scratchWe = 1; scratchIn = 8'h33; instrEnd = 1; step("R10 clear wins");
    chk("R10 literal clear", scratch, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    #35;
    t_reset();
    @(negedge clk); rstN = 1;
    @(posedge clk); #2;
    t_arith();
    t_logic();
    t_none();
    t_bits();
    t_load();
    t_int();
    t_scratch();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule